// File: doc/BRIEF.md
# Aliased Packed-Integer / Floating-Point Register File

This block holds eight 80-bit physical registers and offers two ways to reach them. The packed-integer view sees eight 64-bit registers, and its register number is the physical register number. The floating-point view treats the same eight registers as a stack. Its index is relative to a 3-bit top-of-stack pointer, and that pointer sits in a 16-bit status word. Each view has one write port and one combinational read port.

Activity on the packed-integer side changes the floating-point bookkeeping:

- A packed-integer write fills bits 79:64 of the target register with ones.
- Any packed-integer activity marks all eight 2-bit tags valid.
- Any packed-integer activity sets the stack pointer back to zero.

A separate "empty SIMD state" command marks every tag empty and leaves the data alone. Push and pop inputs move the stack pointer, which lets the two mappings be compared against each other. The block models only the aliasing and these side effects. It performs no arithmetic.

Top module: `aliased_simd_fp_rf`

## Requirements
- R1: While reset is held and after reset: every register is zero, `tag_word` is 16'hFFFF and `status_word` is 16'h0000.
- R2: `simd_rd_data` is bits 63:0 of physical register `simd_rd_idx`, whatever the stack pointer holds.
- R3: A packed-integer write to register i stores its data in bits 63:0 of physical register i and sets bits 79:64 to 16'hFFFF in the same edge.
- R4: Floating-point stack index k, on both the read and the write port, selects physical register (TOS + k) mod 8. TOS is the value held before the current edge.
- R5: A floating-point write places all 80 bits in the selected register. From the next cycle, its low 64 bits read back through the packed-integer register with the same physical number.
- R6: A cycle with `simd_wr_en` or `simd_op_en` high and `simd_empty` low sets all tags to 2'b00 (valid), so `tag_word` becomes 16'h0000.
- R7: A cycle with `simd_wr_en` or `simd_op_en` high sets TOS to 0 at the next edge, regardless of push or pop in that cycle.
- R8: `simd_empty` sets every tag to 2'b11 (`tag_word` = 16'hFFFF), even if a packed-integer operation occurs in the same cycle. It changes no register data, and on its own it leaves TOS unchanged.
- R9: When there is no packed-integer activity, `fp_push` alone decrements TOS mod 8, `fp_pop` alone increments it mod 8, and both together or neither leave it unchanged.
- R10: If both views write the same physical register in one cycle, the floating-point data (all 80 bits) is stored. The packed-integer side effects on the tags and TOS still apply.
- R11: Reads are combinational from the stored state, so a read of a register being written in the same cycle returns the old contents.
- R12: `status_word` holds TOS in bits 13:11 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| simd_wr_en | input | 1 | Packed-integer write enable |
| simd_wr_idx | input | 3 | Packed-integer write register number |
| simd_wr_data | input | 64 | Packed-integer write data |
| simd_op_en | input | 1 | Packed-integer operation executed without a register write |
| simd_empty | input | 1 | Empty-SIMD-state command |
| simd_rd_idx | input | 3 | Packed-integer read register number |
| simd_rd_data | output | 64 | Packed-integer read data |
| fp_wr_en | input | 1 | Floating-point write enable |
| fp_wr_idx | input | 3 | Floating-point write stack index |
| fp_wr_data | input | 80 | Floating-point write data |
| fp_push | input | 1 | Decrement stack pointer |
| fp_pop | input | 1 | Increment stack pointer |
| fp_rd_idx | input | 3 | Floating-point read stack index |
| fp_rd_data | output | 80 | Floating-point read data |
| tag_word | output | 16 | Two tag bits per physical register, register i at bits 2i+1:2i |
| status_word | output | 16 | TOS at bits 13:11, other bits zero |

## Verification
The bench targets the following cases and the fault each one would expose:

- **Collision.** Both views write one physical register in the same cycle. A design with the wrong priority keeps the ones-filled 64-bit value instead of the 80-bit floating-point value.
- **Stack index at non-zero TOS.** A floating-point write is made with a non-zero TOS and read back through the fixed packed-integer mapping. A design that applies TOS to the packed-integer side, or forgets it on the floating-point side, returns data from the wrong register.
- **Overlapping commands.** The empty command is issued together with a packed-integer operation, and a push is issued together with a packed-integer write. These expose any priority inversion between tag and pointer updates.
- **Read during write.** Reads are sampled while a write to the same register is pending. A design that forwards write data would return the new value one cycle early.

// File: rtl/arf_pkg.sv
// Package: shared constants and types for the aliased register file.
// Assumes: a two-bit tag per register, with the valid and empty codes below.
package arf_pkg;
    typedef enum logic [1:0] {
        TAG_VALID = 2'b00,
        TAG_EMPTY = 2'b11
    } reg_tag_e;

    localparam int STATUS_W = 16;
endpackage

// File: rtl/arf_stack_map.sv
// Module: arf_stack_map
// Turns a stack-relative index into a physical register number by adding the
// stack pointer modulo the register count.
// Assumes: the register count is a power of two, so wrap-around is free.
module arf_stack_map #(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] tos,
    input  logic [IDX_W-1:0] rel_idx,
    output logic [IDX_W-1:0] phys_idx
);
    // Modular add: the width truncation performs the wrap.
    always_comb begin
        phys_idx = tos + rel_idx;
    end
endmodule

// File: rtl/arf_stack_ptr.sv
// Module: arf_stack_ptr
// Holds the top-of-stack pointer. Packed-integer activity clears it; otherwise
// push decrements it and pop increments it.
// Assumes: push and pop together cancel; reset value is zero.
module arf_stack_ptr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             simd_active,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] tos
);
    localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

    logic [IDX_W-1:0] tos_q;
    logic [IDX_W-1:0] tos_d;

    // Next-pointer selection: clear has priority over stack movement.
    always_comb begin
        tos_d = tos_q;
        if (simd_active) begin
            tos_d = '0;
        end else if (push && !pop) begin
            tos_d = tos_q - STEP;
        end else if (pop && !push) begin
            tos_d = tos_q + STEP;
        end
    end

    // Pointer register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos_q <= '0;
        end else begin
            tos_q <= tos_d;
        end
    end

    assign tos = tos_q;
endmodule

// File: rtl/arf_tag_word.sv
// Module: arf_tag_word
// Holds the per-register tags. The empty command marks all empty; packed-
// integer activity marks all valid; otherwise the tags hold.
// Assumes: the empty command wins over packed-integer activity in one cycle.
module arf_tag_word #(
    parameter int NUM_REGS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    simd_active,
    input  logic                    empty_cmd,
    output logic [2*NUM_REGS-1:0]   tag_word
);
    import arf_pkg::*;

    reg_tag_e tag_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_tag
        // One tag register per physical register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g] <= TAG_EMPTY;
            end else if (empty_cmd) begin
                tag_q[g] <= TAG_EMPTY;
            end else if (simd_active) begin
                tag_q[g] <= TAG_VALID;
            end
        end

        assign tag_word[2*g +: 2] = tag_q[g];
    end
endmodule

// File: rtl/arf_storage.sv
// Module: arf_storage
// Eight-entry physical array with one packed-integer and one floating-point
// write port and two combinational read ports. A packed-integer write fills
// the bits above the integer width with ones. On a same-register collision
// the floating-point write wins.
// Assumes: write indices are physical; reads see pre-edge contents.
module arf_storage #(
    parameter int NUM_REGS = 8,
    parameter int FP_W     = 80,
    parameter int SIMD_W   = 64,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           simd_we,
    input  logic [IDX_W-1:0]               simd_widx,
    input  logic [SIMD_W-1:0]              simd_wdata,
    input  logic                           fp_we,
    input  logic [IDX_W-1:0]               fp_widx,
    input  logic [FP_W-1:0]                fp_wdata,
    input  logic [IDX_W-1:0]               simd_ridx,
    input  logic [IDX_W-1:0]               fp_ridx,
    output logic [SIMD_W-1:0]              simd_rdata,
    output logic [FP_W-1:0]                fp_rdata,
    output logic [NUM_REGS-1:0][FP_W-1:0]  regs
);
    localparam int UP_W = FP_W - SIMD_W;

    logic [NUM_REGS-1:0][FP_W-1:0] regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic fp_hit;
        logic simd_hit;

        // Per-register write decode.
        always_comb begin
            fp_hit   = fp_we   && (fp_widx   == IDX_W'(g));
            simd_hit = simd_we && (simd_widx == IDX_W'(g));
        end

        // Register storage: floating-point data has priority on collision.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (fp_hit) begin
                regs_q[g] <= fp_wdata;
            end else if (simd_hit) begin
                regs_q[g] <= {{UP_W{1'b1}}, simd_wdata};
            end
        end
    end

    // Combinational read ports from stored state.
    always_comb begin
        simd_rdata = regs_q[simd_ridx][SIMD_W-1:0];
        fp_rdata   = regs_q[fp_ridx];
    end

    assign regs = regs_q;
endmodule

// File: rtl/aliased_simd_fp_rf.sv
// Module: aliased_simd_fp_rf (top)
// Shared register file seen as fixed-numbered 64-bit packed-integer registers
// and as an 80-bit floating-point stack. It drives the tag word and the
// status word (pointer in bits 13:11).
// Assumes: eight registers, so the 3-bit pointer fits the status field.
module aliased_simd_fp_rf #(
    parameter int NUM_REGS = 8,
    parameter int FP_W     = 80,
    parameter int SIMD_W   = 64,
    parameter int TOS_LSB  = 11
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              simd_wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]       simd_wr_idx,
    input  logic [SIMD_W-1:0]                 simd_wr_data,
    input  logic                              simd_op_en,
    input  logic                              simd_empty,
    input  logic [$clog2(NUM_REGS)-1:0]       simd_rd_idx,
    output logic [SIMD_W-1:0]                 simd_rd_data,
    input  logic                              fp_wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]       fp_wr_idx,
    input  logic [FP_W-1:0]                   fp_wr_data,
    input  logic                              fp_push,
    input  logic                              fp_pop,
    input  logic [$clog2(NUM_REGS)-1:0]       fp_rd_idx,
    output logic [FP_W-1:0]                   fp_rd_data,
    output logic [2*NUM_REGS-1:0]             tag_word,
    output logic [arf_pkg::STATUS_W-1:0]      status_word
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic                          simd_active;
    logic [IDX_W-1:0]              tos;
    logic [IDX_W-1:0]              fp_wr_phys;
    logic [IDX_W-1:0]              fp_rd_phys;
    logic [NUM_REGS-1:0][FP_W-1:0] phys_regs;

    // Any packed-integer activity that triggers floating-point side effects.
    always_comb begin
        simd_active = simd_wr_en || simd_op_en;
    end

    arf_stack_ptr #(.IDX_W(IDX_W)) u_tos (
        .clk         (clk),
        .rst_n       (rst_n),
        .simd_active (simd_active),
        .push        (fp_push),
        .pop         (fp_pop),
        .tos         (tos)
    );

    arf_stack_map #(.IDX_W(IDX_W)) u_wr_map (
        .tos      (tos),
        .rel_idx  (fp_wr_idx),
        .phys_idx (fp_wr_phys)
    );

    arf_stack_map #(.IDX_W(IDX_W)) u_rd_map (
        .tos      (tos),
        .rel_idx  (fp_rd_idx),
        .phys_idx (fp_rd_phys)
    );

    arf_tag_word #(.NUM_REGS(NUM_REGS)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .simd_active (simd_active),
        .empty_cmd   (simd_empty),
        .tag_word    (tag_word)
    );

    arf_storage #(
        .NUM_REGS (NUM_REGS),
        .FP_W     (FP_W),
        .SIMD_W   (SIMD_W),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .simd_we    (simd_wr_en),
        .simd_widx  (simd_wr_idx),
        .simd_wdata (simd_wr_data),
        .fp_we      (fp_wr_en),
        .fp_widx    (fp_wr_phys),
        .fp_wdata   (fp_wr_data),
        .simd_ridx  (simd_rd_idx),
        .fp_ridx    (fp_rd_phys),
        .simd_rdata (simd_rd_data),
        .fp_rdata   (fp_rd_data),
        .regs       (phys_regs)
    );

    // Status word assembly: pointer field only, other bits zero.
    always_comb begin
        status_word = '0;
        status_word[TOS_LSB +: IDX_W] = tos;
    end
endmodule

// File: rtl/arf_checker.sv
// Module: arf_checker
// Temporal properties for aliased_simd_fp_rf, attached by bind below.
// Assumes: default parameters (eight registers, pointer at status bits 13:11).
module arf_checker #(
    parameter int NUM_REGS = 8,
    parameter int FP_W     = 80,
    parameter int SIMD_W   = 64
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            simd_wr_en,
    input logic [$clog2(NUM_REGS)-1:0]     simd_wr_idx,
    input logic                            simd_op_en,
    input logic                            simd_empty,
    input logic                            fp_wr_en,
    input logic                            fp_push,
    input logic                            fp_pop,
    input logic [$clog2(NUM_REGS)-1:0]     fp_wr_phys,
    input logic [NUM_REGS-1:0][FP_W-1:0]   phys_regs,
    input logic [2*NUM_REGS-1:0]           tag_word,
    input logic [15:0]                     status_word
);
    assert_tos_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (simd_wr_en || simd_op_en) |=> status_word[13:11] == 3'd0);

    assert_tags_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((simd_wr_en || simd_op_en) && !simd_empty) |=> tag_word == '0);

    assert_tags_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        simd_empty |=> tag_word == '1);

    assert_upper_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (simd_wr_en && !(fp_wr_en && fp_wr_phys == simd_wr_idx))
        |=> phys_regs[$past(simd_wr_idx)][FP_W-1:SIMD_W] == '1);

    assert_push_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_push && !fp_pop && !simd_wr_en && !simd_op_en)
        |=> status_word[13:11] == $past(status_word[13:11]) - 3'd1);

    assert_status_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[10:0] == 11'd0 && status_word[15:14] == 2'd0);
endmodule

bind aliased_simd_fp_rf arf_checker #(
    .NUM_REGS (NUM_REGS),
    .FP_W     (FP_W),
    .SIMD_W   (SIMD_W)
) u_arf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .simd_wr_en  (simd_wr_en),
    .simd_wr_idx (simd_wr_idx),
    .simd_op_en  (simd_op_en),
    .simd_empty  (simd_empty),
    .fp_wr_en    (fp_wr_en),
    .fp_push     (fp_push),
    .fp_pop      (fp_pop),
    .fp_wr_phys  (fp_wr_phys),
    .phys_regs   (phys_regs),
    .tag_word    (tag_word),
    .status_word (status_word)
);

// File: tb/aliased_simd_fp_rf_tb.sv
`timescale 1ns/1ps
module aliased_simd_fp_rf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        simd_wr_en = 1'b0;
    logic [2:0]  simd_wr_idx = '0;
    logic [63:0] simd_wr_data = '0;
    logic        simd_op_en = 1'b0;
    logic        simd_empty = 1'b0;
    logic [2:0]  simd_rd_idx = '0;
    logic [63:0] simd_rd_data;
    logic        fp_wr_en = 1'b0;
    logic [2:0]  fp_wr_idx = '0;
    logic [79:0] fp_wr_data = '0;
    logic        fp_push = 1'b0;
    logic        fp_pop = 1'b0;
    logic [2:0]  fp_rd_idx = '0;
    logic [79:0] fp_rd_data;
    logic [15:0] tag_word;
    logic [15:0] status_word;

    int checks = 0;
    int errors = 0;

    logic [79:0] m_regs [8];
    logic [15:0] m_tag;
    logic [2:0]  m_tos;

    always #2 clk = ~clk;

    aliased_simd_fp_rf dut_i (
        .clk(clk), .rst_n(rst_n),
        .simd_wr_en(simd_wr_en), .simd_wr_idx(simd_wr_idx), .simd_wr_data(simd_wr_data),
        .simd_op_en(simd_op_en), .simd_empty(simd_empty),
        .simd_rd_idx(simd_rd_idx), .simd_rd_data(simd_rd_data),
        .fp_wr_en(fp_wr_en), .fp_wr_idx(fp_wr_idx), .fp_wr_data(fp_wr_data),
        .fp_push(fp_push), .fp_pop(fp_pop),
        .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data),
        .tag_word(tag_word), .status_word(status_word)
    );

    function automatic logic [2:0] stack_phys(input logic [2:0] tos, input logic [2:0] k);
        return tos + k;
    endfunction

    function automatic logic [15:0] exp_status(input logic [2:0] tos);
        return {2'b00, tos, 11'd0};
    endfunction

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_tag = 16'hFFFF;
        m_tos = 3'd0;
    endtask

    // Compare read ports and state outputs against the model (pre-edge state).
    task automatic compare_model();
        check("R2", {16'd0, simd_rd_data}, {16'd0, m_regs[simd_rd_idx][63:0]});
        check("R4", fp_rd_data, m_regs[stack_phys(m_tos, fp_rd_idx)]);
        check("R6", {64'd0, tag_word}, {64'd0, m_tag});
        check("R12", {64'd0, status_word}, {64'd0, exp_status(m_tos)});
    endtask

    // Apply the edge to the model with the inputs currently driven.
    task automatic model_edge();
        logic [2:0] fp_p;
        logic act;
        fp_p = stack_phys(m_tos, fp_wr_idx);
        act = simd_wr_en || simd_op_en;
        if (simd_wr_en) m_regs[simd_wr_idx] = {16'hFFFF, simd_wr_data};
        if (fp_wr_en) m_regs[fp_p] = fp_wr_data;
        if (simd_empty) m_tag = 16'hFFFF;
        else if (act) m_tag = 16'h0000;
        if (act) m_tos = 3'd0;
        else if (fp_push && !fp_pop) m_tos = m_tos - 3'd1;
        else if (fp_pop && !fp_push) m_tos = m_tos + 3'd1;
    endtask

    task automatic idle_inputs();
        simd_wr_en = 0; simd_op_en = 0; simd_empty = 0;
        fp_wr_en = 0; fp_push = 0; fp_pop = 0;
    endtask

    // Called right after a falling edge with inputs set.
    task automatic tick();
        #1;
        compare_model();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        model_reset();
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state while reset held
        #1;
        check("R1", {64'd0, tag_word}, {64'd0, 16'hFFFF});
        check("R1", {64'd0, status_word}, 80'd0);
        check("R1", fp_rd_data, 80'd0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        check("R1", {64'd0, tag_word}, {64'd0, 16'hFFFF});

        // R9: push three times, pop once, push+pop together
        fp_push = 1; tick(); tick(); tick();
        check("R9", {64'd0, status_word}, {64'd0, exp_status(3'd5)});
        fp_push = 0; fp_pop = 1; tick();
        check("R9", {64'd0, status_word}, {64'd0, exp_status(3'd6)});
        fp_push = 1; tick();
        check("R9", {64'd0, status_word}, {64'd0, exp_status(3'd6)});
        idle_inputs();

        // R4/R5: FP write at index 2 with TOS 6 lands in physical 0
        fp_wr_en = 1; fp_wr_idx = 3'd2; fp_wr_data = 80'h1234_89AB_CDEF_0123_4567;
        simd_rd_idx = 3'd0; fp_rd_idx = 3'd2;
        tick();
        idle_inputs();
        #1;
        check("R5", {16'd0, simd_rd_data}, {16'd0, 64'h89AB_CDEF_0123_4567});
        check("R4", fp_rd_data, 80'h1234_89AB_CDEF_0123_4567);
        @(negedge clk);

        // R11 then R3/R6/R7: SIMD write to reg 1, read same reg in same cycle
        simd_wr_en = 1; simd_wr_idx = 3'd1; simd_wr_data = 64'hDEAD_BEEF_0BAD_F00D;
        simd_rd_idx = 3'd1; fp_rd_idx = 3'd1;
        #1;
        check("R11", {16'd0, simd_rd_data}, 80'd0);
        @(negedge clk);
        model_edge_skip: begin end
        idle_inputs();
        // The model was not advanced above; do it against the held write.
        simd_wr_en = 1; #0;
        m_regs[1] = {16'hFFFF, 64'hDEAD_BEEF_0BAD_F00D}; m_tag = 16'h0; m_tos = 3'd0;
        simd_wr_en = 0;
        #1;
        check("R3", fp_rd_data, {16'hFFFF, 64'hDEAD_BEEF_0BAD_F00D});
        check("R6", {64'd0, tag_word}, 80'd0);
        check("R7", {64'd0, status_word}, 80'd0);
        @(negedge clk);

        // R7: push together with a SIMD op still clears TOS
        fp_pop = 1; tick(); fp_pop = 0;
        fp_push = 1; simd_op_en = 1; tick();
        check("R7", {64'd0, status_word}, 80'd0);
        idle_inputs();

        // R10: both views write physical 0 (TOS 7, stack index 1)
        fp_push = 1; tick(); idle_inputs();
        simd_empty = 1; tick(); idle_inputs();
        fp_wr_en = 1; fp_wr_idx = 3'd1; fp_wr_data = 80'hAAAA_5555_6666_7777_8888;
        simd_wr_en = 1; simd_wr_idx = 3'd0; simd_wr_data = 64'h0101_0202_0303_0404;
        simd_rd_idx = 3'd0; fp_rd_idx = 3'd0;
        tick();
        idle_inputs();
        #1;
        check("R10", fp_rd_data, 80'hAAAA_5555_6666_7777_8888);
        check("R10", {64'd0, tag_word}, 80'd0);
        check("R10", {64'd0, status_word}, 80'd0);
        @(negedge clk);

        // R8: empty with a SIMD op; then empty alone at nonzero TOS
        simd_empty = 1; simd_op_en = 1; tick(); idle_inputs();
        check("R8", {64'd0, tag_word}, {64'd0, 16'hFFFF});
        check("R8", fp_rd_data, 80'hAAAA_5555_6666_7777_8888);
        fp_pop = 1; tick(); tick(); idle_inputs();
        simd_empty = 1; tick(); idle_inputs();
        check("R8", {64'd0, status_word}, {64'd0, exp_status(3'd2)});

        // Random phase with occasional overlaps
        for (int n = 0; n < 3000; n++) begin
            simd_wr_en   = ($urandom % 4) == 0;
            simd_wr_idx  = 3'($urandom);
            simd_wr_data = {$urandom, $urandom};
            simd_op_en   = ($urandom % 8) == 0;
            simd_empty   = ($urandom % 16) == 0;
            fp_wr_en     = ($urandom % 3) == 0;
            fp_wr_idx    = 3'($urandom);
            fp_wr_data   = {16'($urandom), $urandom, $urandom};
            fp_push      = ($urandom % 3) == 0;
            fp_pop       = ($urandom % 3) == 0;
            simd_rd_idx  = 3'($urandom);
            fp_rd_idx    = 3'($urandom);
            tick();
        end
        idle_inputs();
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule